// File: doc/BRIEF.md
# Vertical Line-Rate Converter (5:6 / 6:5)

This block converts the number of active video lines per frame between a 525-line-style picture and a common-intermediate-format picture. It accepts a stream of video lines, one pixel per valid cycle, and produces a stream of output lines. In up mode it produces six output lines for every five input lines. In down mode it produces five output lines for every six input lines. A bypass mode reproduces each input line unchanged.

Each output pixel is a blend of the co-sited pixels of the two most recent input lines. The weights come from a polyphase coefficient set in eighths, chosen by the position of the output line within the cadence. Every output line carries a phase index. The cadence counter and the operating mode are both taken at a frame-start pulse, so the pattern always lines up with the top of the picture.

Three line buffers are used in rotation. An output line is replayed from the buffers once the last pixel of an input line has been written, which gives one line of latency. The source must leave at least two line lengths plus two cycles between the ends of consecutive input lines.

Top module: `line_rate_conv`

## Requirements
- R1: After reset `out_vld` and `out_eol` stay low until an input line has been completed.
- R2: Mode code 0, and also code 3, is bypass. Every input line produces exactly one output line equal to it pixel for pixel, with phase 0.
- R3: Mode code 1 is up mode. The first input line after a frame start yields one output line with phase 0. Later input lines with cadence index 1 to 4 (counted modulo 5 from the frame start) each yield one line with phase equal to that index. Each later line with index 0 yields two lines: phase 5, then phase 0.
- R4: In up mode the phases 1, 2, 3, 4 and 5 give the newer line a weight w of 7, 5, 4, 3 and 1 eighths. Each output pixel is (older*(8-w) + newer*w + 4) >> 3. Phase 0 is an exact copy of the newer line.
- R5: Mode code 2 is down mode. An input line with cadence index 1 (counted modulo 6 from the frame start) produces no output at all. Index 0 yields one copy line with phase 0. Index k from 2 to 5 yields one line with phase k-1.
- R6: In down mode the phases 1, 2, 3 and 4 give the newer line a weight w of 2, 3, 5 and 6 eighths, using the same rounding formula as R4.
- R7: A frame-start pulse restarts the cadence at index 0, even in the middle of a group.
- R8: The mode is sampled only on the frame-start pulse. A change of `mode_sel` during a frame has no effect on that frame's output.
- R9: Each output line has as many pixels as the input line it came from. `out_eol` is high on its last pixel only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | 0/3 bypass, 1 up (5 to 6), 2 down (6 to 5); sampled at frame start |
| in_sof | input | 1 | Frame-start pulse, given between lines |
| in_vld | input | 1 | Input pixel valid |
| in_pix | input | DW | Input pixel value |
| in_eol | input | 1 | Marks the last valid pixel of an input line |
| out_vld | output | 1 | Output pixel valid |
| out_pix | output | DW | Output pixel value |
| out_eol | output | 1 | Marks the last pixel of an output line |
| out_phase | output | 3 | Polyphase index of the current output line |

## Verification
The bench builds the block with 8-pixel lines and 8-bit pixels. Each replayed line is then short, so the bench can cover many full cadence groups in a few thousand cycles. These include both wrap points of the up cadence and the dropped line of the down cadence. Pixel patterns include full-scale alternation between 0 and 255, which tests the rounding at the widest accumulator value. A second frame start in the middle of a group and a mode change in the middle of a frame are also covered.

// File: rtl/lrc_pkg.sv
// Package: shared mode type and polyphase weight functions for the
// line-rate converter. Weights are in eighths of the newer line.
package lrc_pkg;

    typedef enum logic [1:0] {
        LRC_PASS = 2'd0,
        LRC_UP   = 2'd1,
        LRC_DOWN = 2'd2
    } lrc_mode_e;

    localparam int WGT_W     = 4;
    localparam int PH_W      = 3;
    localparam int UP_GROUP  = 5;   // input lines per up-mode group
    localparam int DN_GROUP  = 6;   // input lines per down-mode group

    // Newer-line weight for up phase p (1..5): round(8*(6-p)/6).
    function automatic logic [WGT_W-1:0] up_weight(input logic [PH_W-1:0] p);
        int unsigned v;
        v = (16 * (6 - int'(p)) + 6) / 12;
        return WGT_W'(v);
    endfunction

    // Newer-line weight for down phase q (1..4): round(8*q/5).
    function automatic logic [WGT_W-1:0] down_weight(input logic [PH_W-1:0] q);
        int unsigned v;
        v = (16 * int'(q) + 5) / 10;
        return WGT_W'(v);
    endfunction

endpackage

// File: rtl/lrc_cadence.sv
// Cadence controller: latches the mode at frame start, and counts input
// lines within a group. When a line ends it issues a replay job: how many
// output lines to make (0..2), plus the weight and phase of the first one.
// Assumes in_sof never coincides with line_done.
module lrc_cadence
    import lrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             sof,
    input  logic             line_done,
    output lrc_mode_e        mode_q,
    output logic [1:0]       job_lines,
    output logic [WGT_W-1:0] job_w,
    output logic [PH_W-1:0]  job_ph
);

    logic [PH_W-1:0] cnt;
    logic            first;

    // Mode latch and cadence counter, both restarted by frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= LRC_PASS;
            cnt    <= '0;
            first  <= 1'b1;
        end else if (sof) begin
            case (mode_sel)
                2'd1:    mode_q <= LRC_UP;
                2'd2:    mode_q <= LRC_DOWN;
                default: mode_q <= LRC_PASS;
            endcase
            cnt   <= '0;
            first <= 1'b1;
        end else if (line_done) begin
            first <= 1'b0;
            if (mode_q == LRC_UP)
                cnt <= (cnt == PH_W'(UP_GROUP - 1)) ? '0 : cnt + 1'b1;
            else if (mode_q == LRC_DOWN)
                cnt <= (cnt == PH_W'(DN_GROUP - 1)) ? '0 : cnt + 1'b1;
        end
    end

    // Job decode from the current cadence position.
    always_comb begin
        job_lines = 2'd1;
        job_w     = WGT_W'(8);
        job_ph    = '0;
        case (mode_q)
            LRC_UP: begin
                if (!first && cnt == '0) begin
                    job_lines = 2'd2;
                    job_ph    = PH_W'(5);
                    job_w     = up_weight(PH_W'(5));
                end else if (cnt != '0) begin
                    job_ph = cnt;
                    job_w  = up_weight(cnt);
                end
            end
            LRC_DOWN: begin
                if (cnt == PH_W'(1)) begin
                    job_lines = 2'd0;
                end else if (cnt != '0) begin
                    job_ph = cnt - 1'b1;
                    job_w  = down_weight(cnt - 1'b1);
                end
            end
            default: ;
        endcase
    end

    // R3
    // A double job only appears at an up-mode group wrap after the first line.
    cad_pair_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_done && job_lines == 2'd2) |-> (mode_q == LRC_UP && !first));

    // R7
    cad_sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (cnt == '0 && first));

    // R8
    cad_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |=> $stable(mode_q));

endmodule

// File: rtl/lrc_linestore.sv
// Line store: three rotating line buffers. The writer fills one buffer.
// At the end of a line it reports which buffers hold the newest and the
// previous line, and the index of the line's last pixel. Reads are
// asynchronous. Assumes no line is longer than NPIX pixels.
module lrc_linestore #(
    parameter int DW   = 8,
    parameter int NPIX = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_vld,
    input  logic [DW-1:0]            wr_pix,
    input  logic                     wr_eol,
    output logic [1:0]               cur_sel,
    output logic [1:0]               prev_sel,
    output logic [$clog2(NPIX)-1:0]  cur_last,
    input  logic [1:0]               rd_new_sel,
    input  logic [1:0]               rd_old_sel,
    input  logic [$clog2(NPIX)-1:0]  rd_addr,
    output logic [DW-1:0]            rd_new,
    output logic [DW-1:0]            rd_old
);
    localparam int NBUF = 3;
    localparam int AW   = $clog2(NPIX);

    logic [1:0]    wsel;
    logic [AW-1:0] wptr;
    logic [DW-1:0] rd_bank [NBUF];

    // Write pointer and buffer rotation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsel <= '0;
            wptr <= '0;
        end else if (wr_vld) begin
            if (wr_eol) begin
                wptr <= '0;
                wsel <= (wsel == 2'(NBUF - 1)) ? '0 : wsel + 1'b1;
            end else begin
                wptr <= wptr + 1'b1;
            end
        end
    end

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        logic [DW-1:0] mem [NPIX];
        // Store the incoming pixel in the active buffer.
        always_ff @(posedge clk) begin
            if (wr_vld && wsel == 2'(b))
                mem[wptr] <= wr_pix;
        end
        assign rd_bank[b] = mem[rd_addr];
    end

    assign cur_sel  = wsel;
    assign prev_sel = (wsel == '0) ? 2'(NBUF - 1) : wsel - 1'b1;
    assign cur_last = wptr;
    assign rd_new   = rd_bank[rd_new_sel];
    assign rd_old   = rd_bank[rd_old_sel];

endmodule

// File: rtl/lrc_replay.sv
// Replay sequencer: steps a read address across the stored line once per
// output line. When the job asks for two lines, it runs a second pass as
// a copy of the newest line with phase 0. Assumes a new job never arrives
// while a replay is running.
module lrc_replay
    import lrc_pkg::*;
#(
    parameter int NPIX = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     job_go,
    input  logic [1:0]               job_lines,
    input  logic [WGT_W-1:0]         job_w,
    input  logic [PH_W-1:0]          job_ph,
    input  logic [1:0]               job_new_sel,
    input  logic [1:0]               job_old_sel,
    input  logic [$clog2(NPIX)-1:0]  job_last,
    output logic                     busy,
    output logic                     at_last,
    output logic [$clog2(NPIX)-1:0]  addr,
    output logic [1:0]               new_sel,
    output logic [1:0]               old_sel,
    output logic [WGT_W-1:0]         w,
    output logic [PH_W-1:0]          ph
);
    localparam int AW = $clog2(NPIX);

    logic [AW-1:0] last;
    logic          second;

    // Job capture and per-pixel address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            second  <= 1'b0;
            addr    <= '0;
            last    <= '0;
            new_sel <= '0;
            old_sel <= '0;
            w       <= '0;
            ph      <= '0;
        end else if (!busy) begin
            if (job_go && job_lines != 2'd0) begin
                busy    <= 1'b1;
                second  <= (job_lines == 2'd2);
                addr    <= '0;
                last    <= job_last;
                new_sel <= job_new_sel;
                old_sel <= job_old_sel;
                w       <= job_w;
                ph      <= job_ph;
            end
        end else if (at_last) begin
            addr <= '0;
            if (second) begin
                second <= 1'b0;
                w      <= WGT_W'(8);
                ph     <= '0;
            end else begin
                busy <= 1'b0;
            end
        end else begin
            addr <= addr + 1'b1;
        end
    end

    assign at_last = (addr == last);

    // R9
    rp_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (job_go && job_lines != 2'd0) |-> !busy);

    // R9
    rp_addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (addr <= last));

endmodule

// File: rtl/lrc_blend.sv
// Two-line blender: a registered weighted sum of the co-sited older and
// newer pixels, in eighths with rounding. A weight of 8 passes the newer
// pixel straight through, so the older buffer may hold stale data.
module lrc_blend
    import lrc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_act,
    input  logic             in_last,
    input  logic [DW-1:0]    pix_old,
    input  logic [DW-1:0]    pix_new,
    input  logic [WGT_W-1:0] w,
    input  logic [PH_W-1:0]  ph,
    output logic             out_vld,
    output logic             out_eol,
    output logic [DW-1:0]    out_pix,
    output logic [PH_W-1:0]  out_phase
);
    localparam int ACC_W = DW + 4;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] w_new;
    logic [ACC_W-1:0] w_old;

    // Weighted sum with a half-step rounding offset.
    always_comb begin
        w_new = ACC_W'(w);
        w_old = ACC_W'(4'd8 - w);
        acc   = ACC_W'(pix_old) * w_old + ACC_W'(pix_new) * w_new + ACC_W'(4);
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            out_eol   <= 1'b0;
            out_pix   <= '0;
            out_phase <= '0;
        end else begin
            out_vld   <= in_act;
            out_eol   <= in_act && in_last;
            out_phase <= ph;
            out_pix   <= (w == WGT_W'(8)) ? pix_new : acc[DW+2:3];
        end
    end

    // R9
    bl_eol_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eol |-> out_vld);

    // R2
    // A copy pass reproduces the newer pixel exactly one cycle later.
    bl_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_act && w == WGT_W'(8)) |=> (out_pix == $past(pix_new)));

endmodule

// File: rtl/line_rate_conv.sv
// Top level: a vertical 5:6 / 6:5 line-rate converter. It joins the line
// store, cadence controller, replay sequencer and blender. Assumes at
// least two line lengths plus two cycles between consecutive in_eol
// pulses, and in_sof only between lines.
module line_rate_conv
    import lrc_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NPIX = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel,
    input  logic          in_sof,
    input  logic          in_vld,
    input  logic [DW-1:0] in_pix,
    input  logic          in_eol,
    output logic          out_vld,
    output logic [DW-1:0] out_pix,
    output logic          out_eol,
    output logic [2:0]    out_phase
);
    localparam int AW = $clog2(NPIX);

    logic             line_done;
    lrc_mode_e        mode_q;
    logic [1:0]       job_lines;
    logic [WGT_W-1:0] job_w;
    logic [PH_W-1:0]  job_ph;
    logic [1:0]       cur_sel, prev_sel, rp_new_sel, rp_old_sel;
    logic [AW-1:0]    cur_last, rp_addr;
    logic [DW-1:0]    rd_new, rd_old;
    logic             rp_busy, rp_last;
    logic [WGT_W-1:0] rp_w;
    logic [PH_W-1:0]  rp_ph;

    assign line_done = in_vld && in_eol;

    lrc_linestore #(.DW(DW), .NPIX(NPIX)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_vld(in_vld), .wr_pix(in_pix), .wr_eol(in_eol),
        .cur_sel(cur_sel), .prev_sel(prev_sel), .cur_last(cur_last),
        .rd_new_sel(rp_new_sel), .rd_old_sel(rp_old_sel), .rd_addr(rp_addr),
        .rd_new(rd_new), .rd_old(rd_old)
    );

    lrc_cadence u_cad (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sof(in_sof),
        .line_done(line_done), .mode_q(mode_q),
        .job_lines(job_lines), .job_w(job_w), .job_ph(job_ph)
    );

    lrc_replay #(.NPIX(NPIX)) u_rep (
        .clk(clk), .rst_n(rst_n),
        .job_go(line_done), .job_lines(job_lines), .job_w(job_w),
        .job_ph(job_ph), .job_new_sel(cur_sel), .job_old_sel(prev_sel),
        .job_last(cur_last),
        .busy(rp_busy), .at_last(rp_last), .addr(rp_addr),
        .new_sel(rp_new_sel), .old_sel(rp_old_sel), .w(rp_w), .ph(rp_ph)
    );

    lrc_blend #(.DW(DW)) u_blend (
        .clk(clk), .rst_n(rst_n),
        .in_act(rp_busy), .in_last(rp_last),
        .pix_old(rd_old), .pix_new(rd_new), .w(rp_w), .ph(rp_ph),
        .out_vld(out_vld), .out_eol(out_eol), .out_pix(out_pix),
        .out_phase(out_phase)
    );

    // R2
    top_pass_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LRC_PASS && line_done) |=> (rp_ph == '0));

    // R5
    top_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_done && job_lines == 2'd0) |-> (mode_q == LRC_DOWN));

endmodule

// File: tb/line_rate_conv_bench.sv
// Scoreboard bench: the line driver computes the expected output lines
// from the requirements and queues them; a monitor pops and compares.
module line_rate_conv_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int NPIX       = 8;
    localparam int GAP        = 2 * NPIX + 6;
    localparam int WATCHDOG   = 100000;

    typedef struct {
        logic [DW-1:0] pix;
        logic          eol;
        logic [2:0]    ph;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_sel = 2'd0;
    logic          in_sof = 1'b0;
    logic          in_vld = 1'b0;
    logic [DW-1:0] in_pix = '0;
    logic          in_eol = 1'b0;
    logic          out_vld, out_eol;
    logic [DW-1:0] out_pix;
    logic [2:0]    out_phase;

    exp_t          sb[$];
    int            n_cmp = 0;
    int            n_bad = 0;
    int            cycles = 0;
    bit            done = 1'b0;

    // model state
    int            m_mode = 0;
    int            m_cnt = 0;
    bit            m_first = 1'b1;
    int            prev_l[NPIX];
    int            cur_l[NPIX];

    always #(CLK_PERIOD/2) clk = ~clk;

    line_rate_conv #(.DW(DW), .NPIX(NPIX)) u_line_rate_conv (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_sof(in_sof),
        .in_vld(in_vld), .in_pix(in_pix), .in_eol(in_eol),
        .out_vld(out_vld), .out_pix(out_pix), .out_eol(out_eol),
        .out_phase(out_phase)
    );

    function automatic int up_w(int p);
        case (p)
            1: return 7; 2: return 5; 3: return 4; 4: return 3; 5: return 1;
            default: return 8;
        endcase
    endfunction

    function automatic int dn_w(int q);
        case (q)
            1: return 2; 2: return 3; 3: return 5; 4: return 6;
            default: return 8;
        endcase
    endfunction

    task automatic push_line(int w, int ph, string req);
        for (int x = 0; x < NPIX; x++) begin
            exp_t e;
            e.pix = DW'((prev_l[x] * (8 - w) + cur_l[x] * w + 4) / 8);
            e.eol = (x == NPIX - 1);
            e.ph  = 3'(ph);
            e.req = req;
            sb.push_back(e);
        end
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic frame_start(int mode);
        @(negedge clk);
        mode_sel = 2'(mode);
        in_sof   = 1'b1;
        @(negedge clk);
        in_sof   = 1'b0;
        m_mode   = (mode == 1 || mode == 2) ? mode : 0;
        m_cnt    = 0;
        m_first  = 1'b1;
    endtask

    // Drive one line; queue the expected output from the model.
    task automatic send_line(int l, int pat);
        for (int x = 0; x < NPIX; x++) begin
            case (pat)
                0: cur_l[x] = (l * 37 + x * 11) & 255;
                1: cur_l[x] = (l % 2 == 0) ? 255 : 0;
                default: cur_l[x] = (x % 2 == 0) ? ((l * 53) & 255) : 255 - ((l * 29) & 255);
            endcase
        end
        if (m_mode == 1) begin
            if (m_first) push_line(8, 0, "R3");
            else if (m_cnt == 0) begin
                push_line(up_w(5), 5, "R4");
                push_line(8, 0, "R3");
            end else push_line(up_w(m_cnt), m_cnt, "R4");
            m_cnt = (m_cnt + 1) % 5;
        end else if (m_mode == 2) begin
            if (m_cnt == 0) push_line(8, 0, "R5");
            else if (m_cnt >= 2) push_line(dn_w(m_cnt - 1), m_cnt - 1, "R6");
            m_cnt = (m_cnt + 1) % 6;
        end else begin
            push_line(8, 0, "R2");
        end
        m_first = 1'b0;
        for (int x = 0; x < NPIX; x++) begin
            @(negedge clk);
            in_vld = 1'b1;
            in_pix = DW'(cur_l[x]);
            in_eol = (x == NPIX - 1);
        end
        @(negedge clk);
        in_vld = 1'b0;
        in_eol = 1'b0;
        for (int x = 0; x < NPIX; x++) prev_l[x] = cur_l[x];
        repeat (GAP) @(negedge clk);
    endtask

    // Monitor: compare each output pixel against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && !done && out_vld) begin
            if (sb.size() == 0) begin
                check(1'b0, "R5/R9 unexpected output pixel", int'(out_pix), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_pix == e.pix, {e.req, " pixel"}, int'(out_pix), int'(e.pix));
                check(out_eol == e.eol, "R9 eol", int'(out_eol), int'(e.eol));
                check(out_phase == e.ph, {e.req, " phase"}, int'(out_phase), int'(e.ph));
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        for (int x = 0; x < NPIX; x++) prev_l[x] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle outputs after reset
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(out_vld == 1'b0, "R1 out_vld", int'(out_vld), 0);
            check(out_eol == 1'b0, "R1 out_eol", int'(out_eol), 0);
        end
        // R2: bypass, code 0 and code 3
        frame_start(0);
        for (int l = 0; l < 3; l++) send_line(l, 0);
        frame_start(3);
        for (int l = 0; l < 2; l++) send_line(l + 7, 2);
        // R3, R4: up mode across several group wraps
        frame_start(1);
        for (int l = 0; l < 12; l++) send_line(l, 0);
        frame_start(1);
        for (int l = 0; l < 11; l++) send_line(l, 1);
        // R5, R6: down mode across several groups
        frame_start(2);
        for (int l = 0; l < 13; l++) send_line(l, 2);
        frame_start(2);
        for (int l = 0; l < 7; l++) send_line(l, 1);
        // R7: restart in the middle of a group
        frame_start(1);
        for (int l = 0; l < 3; l++) send_line(l, 2);
        frame_start(1);
        for (int l = 0; l < 7; l++) send_line(l + 20, 0);
        // R8: mode changed mid-frame has no effect
        frame_start(2);
        for (int l = 0; l < 3; l++) send_line(l, 0);
        mode_sel = 2'd1;
        for (int l = 3; l < 9; l++) send_line(l, 0);
        repeat (2 * NPIX + 10) @(negedge clk);
        // R3/R5: no expected line left unproduced
        check(sb.size() == 0, "R3/R5 pending lines", sb.size(), 0);
        finish_run();
    end

endmodule